// File: doc/BRIEF.md
# Forward-warp subpixel depth-composite buffer

This block collects image samples that a warp unit has already pushed forward into screen space. It resolves visibility for a square screen region. Every pixel of the region holds four subpixel cells laid out as a 2x2 grid. Each sample names a pixel, a 2-bit offset that picks one of the four cells, a 16-bit depth and a colour. A sample replaces the contents of its cell only when it is strictly nearer. The buffer does no interpolation and no filtering.

Two region buffers take turns. While one accepts samples for the region being warped, the other is streamed out cell by cell to the reconstruction filter, and each cell is wiped as it leaves. The warp side signals the end of a region with a one-cycle pulse. The buffers trade roles only once the previous stream has finished. Until then, the sample input holds off with its ready signal low. The region size is a parameter: the full-size region is 128x128 pixels, and smaller instances serve for testing.

Top module: `fwd_zcomp_buf`

## Requirements
- R1: After reset, `s_ready` stays low while both buffers are swept clear. It rises no more than 4*REG_W*REG_H+4 cycles after reset is released.
- R2: An accepted sample goes to subpixel cell index `{s_off[1], s_off[0]}` of pixel (`s_x`, `s_y`). Offset bit 0 is the horizontal half and bit 1 is the vertical half, so each offset value reaches its own cell.
- R3: A sample is stored only if its depth is strictly smaller than the stored depth. An equal or larger depth leaves the cell unchanged. A sample of depth 16'hFFFF is therefore never stored, and a sample of depth 0 always lands in an empty cell.
- R4: One sample is accepted in every cycle in which `s_valid` and `s_ready` are both high. Samples aimed at the same cell in consecutive cycles still leave the nearest one, whatever the order in which they arrive.
- R5: A `region_done` pulse pulls `s_ready` low from the next cycle on. The buffers swap, and `s_ready` returns high, only after the previous stream has ended: `s_ready` rises in the same cycle that the last cell of that stream is presented. A pulse that arrives while a swap is already pending is absorbed.
- R6: A stream presents all 4*REG_W*REG_H cells of the finished region, one per cycle, with `o_valid` high throughout. The order is pixel by pixel, row after row with x increasing inside a row, and the four cells of each pixel in index order 0 to 3. Each cell carries its `o_x`, `o_y` and `o_sub`. `o_last` marks the final cell.
- R7: Each cell is cleared as it is streamed. When a buffer is filled again, every cell that receives no new sample comes out empty.
- R8: Samples for the next region are accepted while the previous region is streaming. They do not change the cells of the stream in progress.
- R9: An empty cell is presented with `o_cov` = 0, `o_depth` = 16'hFFFF and `o_color` = 0. A stored sample has `o_cov` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample can be taken this cycle |
| s_x | input | $clog2(REG_W) | Pixel column inside the region |
| s_y | input | $clog2(REG_H) | Pixel row inside the region |
| s_off | input | 2 | Subpixel cell select: bit 0 horizontal, bit 1 vertical |
| s_depth | input | 16 | Sample depth, smaller is nearer |
| s_color | input | COLOR_W | Sample colour |
| region_done | input | 1 | One-cycle pulse ending the current region |
| o_valid | output | 1 | Streamed cell present |
| o_x | output | $clog2(REG_W) | Pixel column of the streamed cell |
| o_y | output | $clog2(REG_H) | Pixel row of the streamed cell |
| o_sub | output | 2 | Subpixel index of the streamed cell |
| o_cov | output | 1 | Cell holds a sample |
| o_depth | output | 16 | Cell depth |
| o_color | output | COLOR_W | Cell colour |
| o_last | output | 1 | Final cell of the region |

## Verification
The embedded assertions check several rules on every clock. Each stream starts at the origin cell and steps through consecutive cell indices until `o_last`. Every empty cell shows the cleared depth. The clearing sweep and the compositing path never write the same buffer in the same cycle.

Some behaviour only the directed scenarios can show. These include the depth rule with its equal and far-limit cases, and the nearest-wins result of back-to-back hits on one cell. They also cover the exact cycle in which `s_ready` returns after a stalled `region_done`, and the absence of stale values in a reused buffer. The scenarios compare every streamed cell against a bench model built from the requirements.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int DEPTH_W = 16;
  typedef logic [DEPTH_W-1:0] depth_t;

  // strict comparison: equal depth keeps the resident sample
  function automatic logic nearer(input depth_t cand, input depth_t resident);
    return cand < resident;
  endfunction
endpackage

// File: rtl/zc_bank.sv
module zc_bank #(
  parameter int AW = 8,
  parameter int DW = 41
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [0:ENTRIES-1];

  // simple dual port, registered read, old data on same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/zc_sweep.sv
module zc_sweep #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] TOP = '1;

  assign last = busy && (addr == TOP);

  // reset launches the initial clearing pass
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (addr == TOP) busy <= 1'b0;
      else             addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/zc_depth_stage.sv
module zc_depth_stage
  import zc_pkg::*;
#(
  parameter int AW      = 8,
  parameter int COLOR_W = 24,
  localparam int CELL_W = 1 + DEPTH_W + COLOR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic [AW-1:0]      acc_addr,
  input  depth_t             acc_depth,
  input  logic [COLOR_W-1:0] acc_color,
  input  depth_t             rd_depth,
  output logic               busy,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [CELL_W-1:0]  wr_word
);
  logic               p_v;
  logic [AW-1:0]      p_addr;
  depth_t             p_depth;
  logic [COLOR_W-1:0] p_color;
  logic               f_v;
  depth_t             f_depth;
  depth_t             resident;

  // a write landing on the address being read is bypassed into the compare
  always_ff @(posedge clk) begin
    if (rst) begin
      p_v     <= 1'b0;
      f_v     <= 1'b0;
      p_addr  <= '0;
      p_depth <= '0;
      p_color <= '0;
      f_depth <= '0;
    end else begin
      p_v <= acc;
      f_v <= acc && wr_en && (wr_addr == acc_addr);
      if (acc) begin
        p_addr  <= acc_addr;
        p_depth <= acc_depth;
        p_color <= acc_color;
      end
      f_depth <= p_depth;
    end
  end

  always_comb begin
    resident = f_v ? f_depth : rd_depth;
    wr_en    = p_v && nearer(p_depth, resident);
    wr_addr  = p_addr;
    wr_word  = {1'b1, p_depth, p_color};
  end

  assign busy = p_v;
endmodule

// File: rtl/fwd_zcomp_buf.sv
module fwd_zcomp_buf
  import zc_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int REG_H   = 16,
  parameter int COLOR_W = 24,
  localparam int XW     = $clog2(REG_W),
  localparam int YW     = $clog2(REG_H)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [XW-1:0]      s_x,
  input  logic [YW-1:0]      s_y,
  input  logic [1:0]         s_off,
  input  logic [15:0]        s_depth,
  input  logic [COLOR_W-1:0] s_color,
  input  logic               region_done,
  output logic               o_valid,
  output logic [XW-1:0]      o_x,
  output logic [YW-1:0]      o_y,
  output logic [1:0]         o_sub,
  output logic               o_cov,
  output logic [15:0]        o_depth,
  output logic [COLOR_W-1:0] o_color,
  output logic               o_last
);
  localparam int AW     = YW + XW + 2;
  localparam int CELL_W = 1 + DEPTH_W + COLOR_W;
  localparam logic [CELL_W-1:0] CLEAR_WORD = {1'b0, {DEPTH_W{1'b1}}, {COLOR_W{1'b0}}};

  logic          init_mode, wbank, swap_pend, swap_go;
  logic          sw_busy, sw_last;
  logic [AW-1:0] sw_addr;
  logic          accept;
  logic [AW-1:0] acc_addr;
  logic          cp_busy, cp_wr_en;
  logic [AW-1:0] cp_wr_addr;
  logic [CELL_W-1:0] cp_wr_word;
  logic [CELL_W-1:0] bank_rd [2];
  logic          sw_we [2];
  logic          cp_we [2];
  logic [CELL_W-1:0] cp_rd_word;

  assign s_ready  = !init_mode && !swap_pend;
  assign accept   = s_valid && s_ready;
  assign acc_addr = {s_y, s_x, s_off};
  assign swap_go  = !init_mode && swap_pend && !sw_busy && !cp_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_mode <= 1'b1;
      wbank     <= 1'b0;
      swap_pend <= 1'b0;
    end else begin
      if (init_mode && sw_last) init_mode <= 1'b0;
      if (region_done) swap_pend <= 1'b1;
      if (swap_go) begin
        swap_pend <= 1'b0;
        wbank     <= ~wbank;
      end
    end
  end

  zc_sweep #(.AW(AW)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .start (swap_go),
    .busy  (sw_busy),
    .addr  (sw_addr),
    .last  (sw_last)
  );

  assign cp_rd_word = wbank ? bank_rd[1] : bank_rd[0];

  zc_depth_stage #(.AW(AW), .COLOR_W(COLOR_W)) u_depth (
    .clk       (clk),
    .rst       (rst),
    .acc       (accept),
    .acc_addr  (acc_addr),
    .acc_depth (s_depth),
    .acc_color (s_color),
    .rd_depth  (cp_rd_word[COLOR_W +: DEPTH_W]),
    .busy      (cp_busy),
    .wr_en     (cp_wr_en),
    .wr_addr   (cp_wr_addr),
    .wr_word   (cp_wr_word)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          is_w;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [CELL_W-1:0] wdata;

    assign is_w    = (wbank == 1'(b));
    assign sw_we[b] = sw_busy && (init_mode || !is_w);
    assign cp_we[b] = is_w && cp_wr_en;
    assign we      = sw_we[b] || cp_we[b];
    assign waddr   = sw_we[b] ? sw_addr : cp_wr_addr;
    assign wdata   = sw_we[b] ? CLEAR_WORD : cp_wr_word;
    assign raddr   = is_w ? acc_addr : sw_addr;

    zc_bank #(.AW(AW), .DW(CELL_W)) u_mem (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (bank_rd[b])
    );

    // R8
    no_bank_clash_chk: assert property (@(posedge clk) disable iff (rst)
      !(sw_we[b] && cp_we[b]));
  end

  // readout: address cycle, memory cycle, output register cycle
  logic          rv1, rl1, rb1;
  logic [AW-1:0] ra1;
  logic [CELL_W-1:0] o_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1     <= 1'b0;
      rl1     <= 1'b0;
      rb1     <= 1'b0;
      ra1     <= '0;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      o_word  <= CLEAR_WORD;
      {o_y, o_x, o_sub} <= '0;
    end else begin
      rv1     <= sw_busy && !init_mode;
      rl1     <= sw_last;
      rb1     <= ~wbank;
      ra1     <= sw_addr;
      o_valid <= rv1;
      o_last  <= rv1 && rl1;
      if (rv1) begin
        o_word            <= bank_rd[rb1];
        {o_y, o_x, o_sub} <= ra1;
      end
    end
  end

  assign o_cov   = o_word[CELL_W-1];
  assign o_depth = o_word[COLOR_W +: DEPTH_W];
  assign o_color = o_word[COLOR_W-1:0];

  // R6
  stream_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(o_valid) |-> ({o_y, o_x, o_sub} == '0));

  // R6
  stream_step_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_last |=> o_valid && ({o_y, o_x, o_sub} == $past({o_y, o_x, o_sub}) + 1'b1));

  // R9
  empty_cell_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_cov |-> (o_depth == 16'hFFFF));
endmodule

// File: tb/tb_fwd_zcomp_buf.sv
module tb_fwd_zcomp_buf;
  localparam int W  = 4;
  localparam int H  = 4;
  localparam int CW = 8;
  localparam int N  = 4 * W * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [1:0] s_x = '0;
  logic [1:0] s_y = '0;
  logic [1:0] s_off = '0;
  logic [15:0] s_depth = '0;
  logic [CW-1:0] s_color = '0;
  logic region_done = 1'b0;
  logic o_valid, o_cov, o_last;
  logic [1:0] o_x, o_y, o_sub;
  logic [15:0] o_depth;
  logic [CW-1:0] o_color;

  always #10 clk = ~clk;

  fwd_zcomp_buf #(.REG_W(W), .REG_H(H), .COLOR_W(CW)) dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_x(s_x), .s_y(s_y), .s_off(s_off), .s_depth(s_depth), .s_color(s_color),
    .region_done(region_done), .o_valid(o_valid), .o_x(o_x), .o_y(o_y),
    .o_sub(o_sub), .o_cov(o_cov), .o_depth(o_depth), .o_color(o_color),
    .o_last(o_last)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model of the region being filled and two snapshots of finished regions
  bit          m_cov [N];
  int          m_d   [N];
  int          m_c   [N];
  bit          e_cov [2][N];
  int          e_d   [2][N];
  int          e_c   [2][N];
  int          regions = 0;

  // captured streams, two slots by stream parity
  int c_idx [2][N];
  bit c_cov [2][N];
  int c_d   [2][N];
  int c_c   [2][N];
  int cap_n = 0;
  int cap_len [2];
  int streams = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst && o_valid) begin
      if (cap_n < N) begin
        c_idx[streams % 2][cap_n] = {o_y, o_x, o_sub};
        c_cov[streams % 2][cap_n] = o_cov;
        c_d[streams % 2][cap_n]   = o_depth;
        c_c[streams % 2][cap_n]   = o_color;
      end
      if (o_last) begin
        cap_len[streams % 2] = cap_n + 1;
        cap_n = 0;
        streams++;
      end else begin
        cap_n++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_cov[i] = 1'b0;
      m_d[i]   = 16'hFFFF;
      m_c[i]   = 0;
    end
  endtask

  task automatic send(input int x, input int y, input int off, input int d, input int c);
    int idx;
    @(negedge clk);
    s_valid = 1'b1;
    s_x = 2'(x); s_y = 2'(y); s_off = 2'(off);
    s_depth = 16'(d); s_color = CW'(c);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    idx = (y * W + x) * 4 + off;
    if (d < m_d[idx]) begin
      m_cov[idx] = 1'b1;
      m_d[idx]   = d;
      m_c[idx]   = c;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic end_region();
    @(negedge clk);
    region_done = 1'b1;
    for (int i = 0; i < N; i++) begin
      e_cov[regions % 2][i] = m_cov[i];
      e_d[regions % 2][i]   = m_d[i];
      e_c[regions % 2][i]   = m_c[i];
    end
    regions++;
    model_clear();
    @(negedge clk);
    region_done = 1'b0;
    chk(s_ready == 1'b0, "R5 ready drop after region_done", s_ready, 0);
  endtask

  // compare stream k (1-based) with the k-th snapshot
  task automatic check_stream(input int k, input string tag);
    int s;
    s = (k - 1) % 2;
    while (streams < k) @(negedge clk);
    chk(cap_len[s] == N, "R6 stream length", cap_len[s], N);
    for (int i = 0; i < N; i++) begin
      chk(c_idx[s][i] == i, "R6 cell order", c_idx[s][i], i);
      if (!(c_cov[s][i] == e_cov[s][i] && c_d[s][i] == e_d[s][i] && c_c[s][i] == e_c[s][i])) begin
        $display("  cell %0d: cov %0d/%0d colour %0d/%0d", i,
                 c_cov[s][i], e_cov[s][i], c_c[s][i], e_c[s][i]);
        chk(1'b0, tag, c_d[s][i], e_d[s][i]);
      end else begin
        chk(1'b1, tag, c_d[s][i], e_d[s][i]);
      end
    end
  endtask

  // R1: input held off while both buffers are cleared
  task automatic test_reset();
    int cnt;
    model_clear();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b0, "R1 ready low during clear", s_ready, 0);
    cnt = 1;
    while (!s_ready && cnt < 4 * N) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt <= N + 4, "R1 clear duration", cnt, N + 4);
  endtask

  // R2, R3, R9: cell selection and depth rule
  task automatic test_fill_first();
    send(0, 0, 0, 100, 8'h11);
    send(0, 0, 1, 200, 8'h12);
    send(0, 0, 2, 300, 8'h13);
    send(0, 0, 3, 400, 8'h14);
    send(3, 2, 1, 500, 8'h21);
    send(3, 2, 1, 500, 8'h22);
    send(3, 2, 1, 600, 8'h23);
    send(3, 2, 1, 499, 8'h24);
    send(1, 3, 2, 16'hFFFF, 8'h31);
    send(2, 1, 3, 0, 8'h41);
    idle();
    end_region();
  endtask

  // R4, R8: back-to-back hits while the previous region streams
  task automatic test_overlap();
    send(1, 1, 0, 50, 8'h50);
    send(1, 1, 0, 40, 8'h40);
    send(1, 1, 0, 45, 8'h45);
    send(1, 1, 0, 30, 8'h30);
    send(1, 1, 0, 35, 8'h35);
    send(1, 1, 1, 10, 8'h0A);
    send(1, 1, 1, 20, 8'h14);
    send(2, 2, 0, 80, 8'h80);
    send(2, 2, 1, 70, 8'h70);
    send(2, 2, 0, 60, 8'h60);
    send(0, 0, 0, 900, 8'h90);
    idle();
    chk(streams == 0, "R8 samples taken during stream", streams, 0);
    check_stream(1, "R2,R3,R9 first region content");
    end_region();
    check_stream(2, "R4,R8 second region content");
  endtask

  // R5, R7: stall while streaming, reused buffer starts empty
  task automatic test_stall();
    send(3, 3, 3, 7, 8'h55);
    idle();
    end_region();
    send(0, 3, 2, 1234, 8'h66);
    idle();
    end_region();
    while (!s_ready) @(negedge clk);
    chk(o_last == 1'b1, "R5 ready returns with last cell", o_last, 1);
    check_stream(3, "R7 reused buffer content");
    check_stream(4, "R5 stalled region content");
  endtask

  initial begin
    test_reset();
    test_fill_first();
    test_overlap();
    test_stall();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule